// File: doc/BRIEF.md
# Low-power wait mode controller

This block sequences the wait low-power mode of a small 8-bit microcontroller. A one-cycle strobe from the core's instruction decode starts it. The block then stops the CPU clock and sends a one-cycle pulse that clears the interrupt mask bit in the condition code register, so that any enabled interrupt source can wake the core. The peripheral clocks are not touched. The timer keeps counting. The serial interface and the A/D converter keep running if their own enables were set before entry. An EEPROM program or erase cycle and its charge pump are left as they were.

While in wait, the block watches a vector of interrupt requests, each with its own enable. The first enabled request moves the block to a one-cycle wake state. In that cycle the CPU clock is running again, a stacking request tells the core to save its context, and the index of the waking source is presented for vectoring. The context is therefore stacked only on the way out of wait. A low level on the external reset pin has priority over all interrupts. The pin is first passed through a synchronizer. A reset request is raised, and the block returns to run without any stacking. A static strap chooses whether the watchdog keeps running or is frozen while the CPU clock is stopped.

Top module: `wait_mode_ctrl`

## Requirements
- R1: While rst_ni is low and right after it rises, cpu_clk_en_o and wdog_en_o are 1; imask_clr_o, stk_req_o and rst_req_o are 0; and wake_src_o is 0.
- R2: A high wait_req_i, sampled in run while rst_req_o is 0, gives cpu_clk_en_o = 0 from the next cycle on. The same cycle carries an imask_clr_o pulse of exactly one cycle.
- R3: While the CPU clock is stopped, wdog_en_o equals wdog_run_i (1 = the watchdog runs, 0 = it is frozen). In run and in the wake cycle, wdog_en_o is 1.
- R4: In wait, a cycle in which any bit of irq_req_i & irq_en_i is 1 is followed by one wake cycle with stk_req_o = 1 and cpu_clk_en_o = 1. The cycle after that is run, with stk_req_o = 0. stk_req_o is never 1 at entry to wait.
- R5: In the wake cycle, wake_src_o holds the lowest bit index that is set in irq_req_i & irq_en_i. It keeps that value until the next wake.
- R6: While no enabled request is present and rst_req_o is 0, the block stays in wait with cpu_clk_en_o = 0 and stk_req_o = 0.
- R7: rst_req_o is the inverse of rst_pin_ni, delayed by SYNC_STAGES clock edges (default 2). If rst_req_o is 1 in wait, the next cycle is run with cpu_clk_en_o = 1 and stk_req_o = 0.
- R8: If rst_req_o and an enabled interrupt request are both present in the same wait cycle, the block returns to run with no stacking request.
- R9: If an enabled request is already pending when the wait strobe is taken, the wake cycle follows the first wait cycle directly.
- R10: wait_req_i has no effect while in wait, while in the wake cycle, or while rst_req_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| wait_req_i | input | 1 | Wait instruction strobe from the core |
| irq_req_i | input | NUM_SRC | Per-source interrupt requests; bit 0 has the highest priority |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| rst_pin_ni | input | 1 | External reset pin, active low, asynchronous to the clock |
| wdog_run_i | input | 1 | Mask-option strap: 1 = watchdog runs in wait |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| wdog_en_o | output | 1 | Watchdog clock enable |
| imask_clr_o | output | 1 | One-cycle pulse that clears the interrupt mask bit |
| stk_req_o | output | 1 | Context stacking request, high during the wake cycle |
| wake_src_o | output | SRC_W | Index of the waking source |
| rst_req_o | output | 1 | Synchronized reset request |

## Verification
The bench sweeps every request pattern across four enable masks and both strap values. Wrong masking would wake on a disabled source, or fail to wake on an enabled one. Reversed priority would report the wrong wake_src_o. A simultaneous reset and interrupt is applied in the exact cycle where both reach the sequencer; a design with the priority inverted would pulse stk_req_o there. Requests pending at entry, and strobes given during wait, wake or reset, are also applied. A design that drops the early request would stay halted. One that accepts a late strobe would stop the clock again straight after waking.

// File: rtl/wait_pkg.sv
package wait_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_WAKE = 2'd2
  } wait_st_e;
endpackage

// File: rtl/wait_rst_sync.sv
module wait_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], pin_ni};
  end

  assign req_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/wait_wake_det.sv
module wait_wake_det #(
  parameter int NUM_SRC = 5,
  parameter int SRC_W   = 3
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               any_o,
  output logic [SRC_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] pend;

  assign pend  = req_i & en_i;
  assign any_o = |pend;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx_o = SRC_W'(i);
    end
  end
endmodule

// File: rtl/wait_fsm.sv
module wait_fsm
  import wait_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wait_req_i,
  input  logic             wake_i,
  input  logic [SRC_W-1:0] wake_idx_i,
  input  logic             rst_req_i,
  input  logic             wdog_run_i,
  output logic             cpu_clk_en_o,
  output logic             wdog_en_o,
  output logic             imask_clr_o,
  output logic             stk_req_o,
  output logic [SRC_W-1:0] wake_src_o
);
  wait_st_e        st_q, st_d;
  logic            clr_q;
  logic [SRC_W-1:0] src_q;
  logic            enter;
  logic            leave_irq;

  assign enter     = (st_q == ST_RUN) && wait_req_i && !rst_req_i;
  assign leave_irq = (st_q == ST_WAIT) && !rst_req_i && wake_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (enter) st_d = ST_WAIT;
      ST_WAIT: begin
        if (rst_req_i)   st_d = ST_RUN;
        else if (wake_i) st_d = ST_WAKE;
      end
      ST_WAKE: st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      clr_q <= 1'b0;
      src_q <= '0;
    end else begin
      st_q  <= st_d;
      clr_q <= enter;
      if (leave_irq) src_q <= wake_idx_i;
    end
  end

  assign cpu_clk_en_o = (st_q != ST_WAIT);
  assign stk_req_o    = (st_q == ST_WAKE);
  assign wdog_en_o    = (st_q == ST_WAIT) ? wdog_run_i : 1'b1;
  assign imask_clr_o  = clr_q;
  assign wake_src_o   = src_q;
endmodule

// File: rtl/wait_mode_ctrl.sv
module wait_mode_ctrl #(
  parameter int NUM_SRC     = 5,
  parameter int SYNC_STAGES = 2,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wait_req_i,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               rst_pin_ni,
  input  logic               wdog_run_i,
  output logic               cpu_clk_en_o,
  output logic               wdog_en_o,
  output logic               imask_clr_o,
  output logic               stk_req_o,
  output logic [SRC_W-1:0]   wake_src_o,
  output logic               rst_req_o
);
  logic             wake;
  logic [SRC_W-1:0] wake_idx;

  wait_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (rst_pin_ni),
    .req_o  (rst_req_o)
  );

  wait_wake_det #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_wake_det (
    .req_i (irq_req_i),
    .en_i  (irq_en_i),
    .any_o (wake),
    .idx_o (wake_idx)
  );

  wait_fsm #(.SRC_W(SRC_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wait_req_i   (wait_req_i),
    .wake_i       (wake),
    .wake_idx_i   (wake_idx),
    .rst_req_i    (rst_req_o),
    .wdog_run_i   (wdog_run_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .wdog_en_o    (wdog_en_o),
    .imask_clr_o  (imask_clr_o),
    .stk_req_o    (stk_req_o),
    .wake_src_o   (wake_src_o)
  );
endmodule

// File: rtl/wait_mode_ctrl_chk.sv
module wait_mode_ctrl_chk #(
  parameter int NUM_SRC = 5,
  parameter int SRC_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wait_req_i,
  input logic [NUM_SRC-1:0] irq_req_i,
  input logic [NUM_SRC-1:0] irq_en_i,
  input logic               wdog_run_i,
  input logic               cpu_clk_en_o,
  input logic               wdog_en_o,
  input logic               imask_clr_o,
  input logic               stk_req_o,
  input logic [SRC_W-1:0]   wake_src_o,
  input logic               rst_req_o
);
  assert_clr_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && !stk_req_o && wait_req_i && !rst_req_o) |=> (imask_clr_o && !cpu_clk_en_o));

  assert_clr_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imask_clr_o |=> !imask_clr_o);

  assert_wdog_strap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_clk_en_o |-> (wdog_en_o == wdog_run_i));

  assert_stk_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_req_o |=> (!stk_req_o && cpu_clk_en_o));

  assert_stk_from_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_req_o |-> ($past(!cpu_clk_en_o) && $past(|(irq_req_i & irq_en_i)) && !$past(rst_req_o)));

  assert_stk_not_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imask_clr_o |-> !stk_req_o);

  assert_src_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_req_o |=> $stable(wake_src_o));

  assert_rst_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && rst_req_o) |=> (cpu_clk_en_o && !stk_req_o));
endmodule

bind wait_mode_ctrl wait_mode_ctrl_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wait_req_i   (wait_req_i),
  .irq_req_i    (irq_req_i),
  .irq_en_i     (irq_en_i),
  .wdog_run_i   (wdog_run_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .wdog_en_o    (wdog_en_o),
  .imask_clr_o  (imask_clr_o),
  .stk_req_o    (stk_req_o),
  .wake_src_o   (wake_src_o),
  .rst_req_o    (rst_req_o)
);

// File: tb/wait_mode_ctrl_tb.sv
`timescale 1ns/1ps
module wait_mode_ctrl_tb_top;
  localparam int NS = 5;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wait_req = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic [NS-1:0] irq_en = '0;
  logic          rst_pin_n = 1'b1;
  logic          wdog_run = 1'b0;
  logic          cpu_clk_en, wdog_en, imask_clr, stk_req, rst_req;
  logic [SW-1:0] wake_src;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wait_mode_ctrl #(.NUM_SRC(NS), .SYNC_STAGES(2)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wait_req_i   (wait_req),
    .irq_req_i    (irq_req),
    .irq_en_i     (irq_en),
    .rst_pin_ni   (rst_pin_n),
    .wdog_run_i   (wdog_run),
    .cpu_clk_en_o (cpu_clk_en),
    .wdog_en_o    (wdog_en),
    .imask_clr_o  (imask_clr),
    .stk_req_o    (stk_req),
    .wake_src_o   (wake_src),
    .rst_req_o    (rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int lowest(input logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return -1;
  endfunction

  // from run: strobe, land in wait, check entry
  task automatic enter_wait(input logic strap);
    wdog_run = strap;
    wait_req = 1'b1;
    tick();
    wait_req = 1'b0;
    chk("R2 cpu_clk_en after strobe", int'(cpu_clk_en), 0);
    chk("R2 imask_clr pulse", int'(imask_clr), 1);
    chk("R3 wdog in wait", int'(wdog_en), int'(strap));
    chk("R4 no stk at entry", int'(stk_req), 0);
    tick();
    chk("R2 imask_clr single", int'(imask_clr), 0);
    chk("R2 still halted", int'(cpu_clk_en), 0);
  endtask

  task automatic scenario(input logic [NS-1:0] r, input logic [NS-1:0] e, input logic strap);
    logic [NS-1:0] p;
    p = r & e;
    irq_en = e;
    irq_req = '0;
    enter_wait(strap);
    irq_req = r;
    tick();
    if (p != '0) begin
      chk("R4 stk in wake", int'(stk_req), 1);
      chk("R4 clk in wake", int'(cpu_clk_en), 1);
      chk("R3 wdog in wake", int'(wdog_en), 1);
      chk("R5 wake_src", int'(wake_src), lowest(p));
      irq_req = '0;
      tick();
      chk("R4 back to run", int'(cpu_clk_en), 1);
      chk("R4 stk single", int'(stk_req), 0);
      chk("R5 wake_src held", int'(wake_src), lowest(p));
    end else begin
      for (int k = 0; k < 3; k++) begin
        chk("R6 stays halted", int'(cpu_clk_en), 0);
        chk("R6 no stk", int'(stk_req), 0);
        chk("R3 wdog strap", int'(wdog_en), int'(strap));
        tick();
      end
      irq_req = 5'b00100;
      irq_en  = 5'b11111;
      tick();
      chk("R4 stk after idle", int'(stk_req), 1);
      chk("R5 wake_src idle exit", int'(wake_src), 2);
      irq_req = '0;
      tick();
      chk("R4 run after idle", int'(cpu_clk_en), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NS-1:0] masks [4];
    masks[0] = 5'h1F; masks[1] = 5'h15; masks[2] = 5'h0A; masks[3] = 5'h00;
    tick();
    chk("R1 cpu_clk_en in reset", int'(cpu_clk_en), 1);
    chk("R1 wdog_en in reset", int'(wdog_en), 1);
    chk("R1 imask_clr in reset", int'(imask_clr), 0);
    chk("R1 stk in reset", int'(stk_req), 0);
    chk("R1 rst_req in reset", int'(rst_req), 0);
    chk("R1 wake_src in reset", int'(wake_src), 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 cpu_clk_en after reset", int'(cpu_clk_en), 1);
    chk("R1 stk after reset", int'(stk_req), 0);

    // R3: outside wait the watchdog ignores the strap
    wdog_run = 1'b0;
    tick();
    chk("R3 wdog in run", int'(wdog_en), 1);

    // pending in run does not stack
    irq_en = 5'h1F; irq_req = 5'h01;
    tick(); tick();
    chk("R4 no stk in run", int'(stk_req), 0);
    irq_req = '0;

    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 32; r++)
          scenario(NS'(r), masks[m], s[0]);

    // R9: request pending before the strobe
    irq_en = 5'h1F; irq_req = 5'b01000;
    wait_req = 1'b1;
    tick();
    wait_req = 1'b0;
    chk("R9 entered wait", int'(cpu_clk_en), 0);
    chk("R9 imask_clr", int'(imask_clr), 1);
    tick();
    chk("R9 wake next cycle", int'(stk_req), 1);
    chk("R9 wake_src", int'(wake_src), 3);
    irq_req = '0;
    tick();

    // R10: strobe during wait and during wake
    irq_en = 5'h1F;
    enter_wait(1'b1);
    wait_req = 1'b1;
    tick();
    chk("R10 strobe in wait no pulse", int'(imask_clr), 0);
    chk("R10 strobe in wait halted", int'(cpu_clk_en), 0);
    irq_req = 5'b10000;
    tick();
    chk("R10 wake with strobe held", int'(stk_req), 1);
    irq_req = '0;
    tick();
    wait_req = 1'b0;
    chk("R10 strobe in wake ignored", int'(cpu_clk_en), 1);
    chk("R10 no pulse after wake", int'(imask_clr), 0);
    tick();
    chk("R10 stays in run", int'(cpu_clk_en), 1);

    // R7: reset exit from wait, with sync latency
    irq_en = '0;
    enter_wait(1'b0);
    rst_pin_n = 1'b0;
    tick();
    chk("R7 rst_req after one edge", int'(rst_req), 0);
    tick();
    chk("R7 rst_req after two edges", int'(rst_req), 1);
    chk("R7 still halted", int'(cpu_clk_en), 0);
    tick();
    chk("R7 run after reset", int'(cpu_clk_en), 1);
    chk("R7 no stk on reset", int'(stk_req), 0);
    // R10: strobe ignored during reset
    wait_req = 1'b1;
    tick();
    wait_req = 1'b0;
    chk("R10 strobe under reset", int'(cpu_clk_en), 1);
    chk("R10 no pulse under reset", int'(imask_clr), 0);
    rst_pin_n = 1'b1;
    tick();
    chk("R7 rst_req held one edge", int'(rst_req), 1);
    tick();
    chk("R7 rst_req released", int'(rst_req), 0);

    // R8: reset and interrupt meet in the same cycle
    irq_en = 5'h1F; irq_req = '0;
    enter_wait(1'b1);
    rst_pin_n = 1'b0;
    tick(); tick();
    chk("R8 rst_req visible", int'(rst_req), 1);
    irq_req = 5'b00010;
    tick();
    chk("R8 no stk", int'(stk_req), 0);
    chk("R8 run", int'(cpu_clk_en), 1);
    tick();
    chk("R8 no late stk", int'(stk_req), 0);
    irq_req = '0;
    rst_pin_n = 1'b1;
    tick(); tick(); tick();
    chk("R8 rst released", int'(rst_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule